// File: doc/BRIEF.md
# YX Dimension-Ordered Mesh Router

This block is one router stop of a two-dimensional on-chip mesh that joins compute tiles, memory controllers and I/O agents. It has four link ports (north, south, east, west) and one local port through which the attached agent injects and receives packets. Every packet carries a destination row and column. The router sends a packet vertically while its row differs from the router's own row. Once the row matches, the packet turns and moves horizontally. When both coordinates match, the packet leaves on the local port.

Traffic already on the mesh always has priority. On each output, a packet continuing straight beats a packet turning from the vertical into the horizontal direction, and both beat a freshly injected packet. A packet that loses waits on its input with its ready held low and is never dropped. Link delay is modelled by a register pipeline on each output: one stage for a vertical hop, two for a horizontal hop and one for ejection. A router instance serves one packet class, such as commands, data or responses, and that class is a parameter. Several instances side by side form the independent class networks.

Top module: `mesh_yx_router`

## Requirements
- R1: Port indices are north=0, south=1, east=2, west=3, local=4. Rows grow southward and columns grow eastward. A packet whose destination row is below the router's row goes north. If the row is above, it goes south. If the row is equal, it goes east when the column is greater, west when the column is smaller, and local when both coordinates match.
- R2: A packet whose destination row differs from the router's row never appears on the east, west or local outputs, whatever its column.
- R3: On the north and south outputs, a packet continuing straight from the opposite vertical input is granted before a packet from the local input.
- R4: On the east and west outputs the priority order is: straight horizontal through traffic, then a packet turning from the north input, then one turning from the south input, then local injection. On the local output the order is north, south, east, west, local.
- R5: A vertical hop takes one cycle. out_valid on the north or south output rises on the clock edge that accepts the packet, provided that output's pipeline is not stalled.
- R6: A horizontal hop takes two cycles from the accepting edge to out_valid on the east or west output.
- R7: Ejection takes one cycle from the accepting edge to out_valid on the local output.
- R8: While out_ready is low, a valid output holds its valid and its packet unchanged. A packet that loses arbitration keeps in_ready low and is delivered later, so no packet is lost.
- R9: Packets that travel from one input to one output leave in the order they were accepted.
- R10: The packet word is, from the MSB down: class (2 bits), row (3), column (3), payload (16). Every field passes through unchanged. Every input packet carries the class given by the PKT_CLASS parameter.
- R11: After reset, every output's out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Packet present on each input port |
| in_ready | output | 5 | Input packet accepted on this edge |
| in_flit | input | 5 x 24 | Input packet per port |
| out_valid | output | 5 | Packet present on each output port |
| out_ready | input | 5 | Downstream accepts the output packet |
| out_flit | output | 5 x 24 | Output packet per port |

## Verification
The routing function is tried three ways. Random packets are injected on all five inputs, each with a destination that is legal for the direction it arrives from, while out_ready toggles at random; this shows whether any packet reaches the wrong output, loses its per-flow order or disappears under backpressure. Directed packets aimed at the same output in the same cycle from through, turning and local sources tell the priority orders apart by the order in which they arrive. Single packets sent into an idle router measure the one- and two-cycle hop delays. A held output shows whether valid and data stay frozen while out_ready is low.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
    parameter int ROW_W  = 3;
    parameter int COL_W  = 3;
    parameter int CLS_W  = 2;
    parameter int PAY_W  = 16;
    parameter int NPORT  = 5;
    localparam int FLIT_W = CLS_W + ROW_W + COL_W + PAY_W;

    localparam int PN = 0;
    localparam int PS = 1;
    localparam int PE = 2;
    localparam int PW = 3;
    localparam int PL = 4;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [PAY_W-1:0] pay;
    } flit_t;

    // k-th input in the priority list of output o (k=0 wins)
    function automatic int prio_port(input int o, input int k);
        int first;
        int cnt;
        int res;
        first = (o == PN) ? PS : (o == PS) ? PN : (o == PE) ? PW : (o == PW) ? PE : PN;
        res = PL;
        if (k == 0) begin
            res = first;
        end else if (k < NPORT - 1) begin
            cnt = 1;
            for (int j = 0; j < NPORT - 1; j++) begin
                if (j != first) begin
                    if (cnt == k) res = j;
                    cnt = cnt + 1;
                end
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/mesh_route_calc.sv
module mesh_route_calc
    import mesh_router_pkg::*;
#(
    parameter logic [ROW_W-1:0] MY_ROW = 3'd3,
    parameter logic [COL_W-1:0] MY_COL = 3'd4
) (
    input  logic [ROW_W-1:0] dst_row,
    input  logic [COL_W-1:0] dst_col,
    output logic [NPORT-1:0] dir
);
    always_comb begin
        dir = '0;
        if (dst_row < MY_ROW)      dir[PN] = 1'b1;
        else if (dst_row > MY_ROW) dir[PS] = 1'b1;
        else if (dst_col > MY_COL) dir[PE] = 1'b1;
        else if (dst_col < MY_COL) dir[PW] = 1'b1;
        else                       dir[PL] = 1'b1;
    end
endmodule

// File: rtl/mesh_prio_arb.sv
module mesh_prio_arb #(
    parameter int N = 5
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && !taken && en) begin
                gnt[k] = 1'b1;
                taken = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_hop_pipe.sv
module mesh_hop_pipe #(
    parameter int DEPTH = 1,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic [DEPTH-1:0]        vld;
        logic [DEPTH-1:0][W-1:0] dat;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic stall;

    assign stall     = st_q.vld[DEPTH-1] & ~out_ready;
    assign in_ready  = ~stall;
    assign out_valid = st_q.vld[DEPTH-1];
    assign out_data  = st_q.dat[DEPTH-1];

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d.vld[0] = in_valid;
            st_d.dat[0] = in_data;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.vld[k] = st_q.vld[k-1];
                st_d.dat[k] = st_q.dat[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mesh_yx_router.sv
module mesh_yx_router
    import mesh_router_pkg::*;
#(
    parameter logic [ROW_W-1:0] MY_ROW    = 3'd3,
    parameter logic [COL_W-1:0] MY_COL    = 3'd4,
    parameter logic [CLS_W-1:0] PKT_CLASS = 2'd1,
    parameter int               Y_HOP_CYC = 1,
    parameter int               X_HOP_CYC = 2,
    parameter int               EJ_CYC    = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              in_valid,
    output logic [NPORT-1:0]              in_ready,
    input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
    output logic [NPORT-1:0]              out_valid,
    input  logic [NPORT-1:0]              out_ready,
    output logic [NPORT-1:0][FLIT_W-1:0]  out_flit
);
    logic [NPORT-1:0][NPORT-1:0] dir;      // [input][output]
    logic [NPORT-1:0][NPORT-1:0] grant;    // [output][input]
    logic [NPORT-1:0]            pipe_rdy;
    logic [NPORT-1:0]            pipe_vld;
    logic [NPORT-1:0][FLIT_W-1:0] pipe_dat;

    for (genvar i = 0; i < NPORT; i++) begin : g_rc
        flit_t f;
        assign f = flit_t'(in_flit[i]);
        mesh_route_calc #(.MY_ROW(MY_ROW), .MY_COL(MY_COL)) u_rc (
            .dst_row(f.row),
            .dst_col(f.col),
            .dir    (dir[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        localparam int DEPTH = (o == PN || o == PS) ? Y_HOP_CYC :
                               (o == PE || o == PW) ? X_HOP_CYC : EJ_CYC;
        logic [NPORT-1:0] req_p;
        logic [NPORT-1:0] gnt_p;

        for (genvar k = 0; k < NPORT; k++) begin : g_perm
            localparam int SRC = prio_port(o, k);
            assign req_p[k]        = in_valid[SRC] & dir[SRC][o];
            assign grant[o][SRC]   = gnt_p[k];
        end

        mesh_prio_arb #(.N(NPORT)) u_arb (
            .en (pipe_rdy[o]),
            .req(req_p),
            .gnt(gnt_p)
        );

        always_comb begin
            pipe_dat[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (grant[o][i]) pipe_dat[o] = pipe_dat[o] | in_flit[i];
            end
        end
        assign pipe_vld[o] = |gnt_p;

        mesh_hop_pipe #(.DEPTH(DEPTH), .W(FLIT_W)) u_pipe (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (pipe_vld[o]),
            .in_ready (pipe_rdy[o]),
            .in_data  (pipe_dat[o]),
            .out_valid(out_valid[o]),
            .out_ready(out_ready[o]),
            .out_data (out_flit[o])
        );
    end

    always_comb begin
        in_ready = '0;
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                if (grant[o][i]) in_ready[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_yx_router_chk.sv
module mesh_yx_router_chk
    import mesh_router_pkg::*;
#(
    parameter logic [ROW_W-1:0] MY_ROW    = 3'd3,
    parameter logic [COL_W-1:0] MY_COL    = 3'd4,
    parameter logic [CLS_W-1:0] PKT_CLASS = 2'd1,
    parameter int               Y_HOP_CYC = 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPORT-1:0]             in_valid,
    input logic [NPORT-1:0]             in_ready,
    input logic [NPORT-1:0][FLIT_W-1:0] in_flit,
    input logic [NPORT-1:0]             out_valid,
    input logic [NPORT-1:0]             out_ready,
    input logic [NPORT-1:0][FLIT_W-1:0] out_flit
);
    flit_t fi [NPORT];
    flit_t fo [NPORT];
    for (genvar p = 0; p < NPORT; p++) begin : g_cast
        assign fi[p] = flit_t'(in_flit[p]);
        assign fo[p] = flit_t'(out_flit[p]);

        AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] && !out_ready[p] |=> out_valid[p] && $stable(out_flit[p])); // R8
        AST_IN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[p] |-> fi[p].cls == PKT_CLASS); // R10
    end

    AST_NORTH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PN] |-> fo[PN].row < MY_ROW); // R1
    AST_SOUTH_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PS] |-> fo[PS].row > MY_ROW); // R1
    AST_X_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[PE] || out_valid[PW]) |-> (fo[PE].row == MY_ROW || !out_valid[PE]) &&
                                            (fo[PW].row == MY_ROW || !out_valid[PW])); // R2
    AST_EJECT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[PL] |-> fo[PL].row == MY_ROW && fo[PL].col == MY_COL); // R2

    AST_Y_THROUGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[PS] && fi[PS].row < MY_ROW && in_valid[PL] && fi[PL].row < MY_ROW
        |-> !in_ready[PL]); // R3
    AST_X_THROUGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[PW] && fi[PW].row == MY_ROW && fi[PW].col > MY_COL &&
        in_valid[PN] && fi[PN].row == MY_ROW && fi[PN].col > MY_COL
        |-> !in_ready[PN]); // R4
    AST_TURN_BEATS_INJECT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[PN] && fi[PN].row == MY_ROW && fi[PN].col > MY_COL &&
        in_valid[PL] && fi[PL].row == MY_ROW && fi[PL].col > MY_COL
        |-> !in_ready[PL]); // R4

    if (Y_HOP_CYC == 1) begin : g_ylat
        AST_Y_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[PS] && in_ready[PS] && fi[PS].row < MY_ROW
            |=> out_valid[PN] && out_flit[PN] == $past(in_flit[PS])); // R5
    end
endmodule

bind mesh_yx_router mesh_yx_router_chk #(
    .MY_ROW(MY_ROW), .MY_COL(MY_COL), .PKT_CLASS(PKT_CLASS), .Y_HOP_CYC(Y_HOP_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
);

// File: tb/mesh_yx_router_test.sv
module mesh_yx_router_test;
    import mesh_router_pkg::*;

    localparam logic [ROW_W-1:0] ME_R = 3'd3;
    localparam logic [COL_W-1:0] ME_C = 3'd4;
    localparam logic [CLS_W-1:0] CLS  = 2'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPORT-1:0] in_valid = '0;
    logic [NPORT-1:0] in_ready;
    logic [NPORT-1:0][FLIT_W-1:0] in_flit = '0;
    logic [NPORT-1:0] out_valid;
    logic [NPORT-1:0] out_ready = '1;
    logic [NPORT-1:0][FLIT_W-1:0] out_flit;

    always #2.5 clk = ~clk;

    mesh_yx_router #(.MY_ROW(ME_R), .MY_COL(ME_C), .PKT_CLASS(CLS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int sent = 0;
    int rcvd = 0;
    int seq_ctr [NPORT];
    int last_seq [NPORT][NPORT];
    int arr_src [NPORT][16];
    int arr_n [NPORT];
    logic rnd_mode = 1'b0;
    logic [NPORT-1:0] hold_mask = '0;
    logic [NPORT-1:0] hs_q = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        hs_q <= in_valid & in_ready;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_port(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
        if (r != ME_R) return (r < ME_R) ? 0 : 1;
        if (c == ME_C) return 4;
        return (c > ME_C) ? 2 : 3;
    endfunction

    function automatic logic [FLIT_W-1:0] mk(input int src, input logic [ROW_W-1:0] r,
                                             input logic [COL_W-1:0] c);
        flit_t f;
        f.cls = CLS;
        f.row = r;
        f.col = c;
        f.pay = {src[2:0], seq_ctr[src][12:0]};
        seq_ctr[src]++;
        sent++;
        return f;
    endfunction

    // output monitor and ready driver
    always @(negedge clk) begin
        for (int o = 0; o < NPORT; o++) begin
            if (rnd_mode) out_ready[o] = ($urandom_range(9, 0) < 7);
            else          out_ready[o] = ~hold_mask[o];
        end
        if (rst_n) begin
            for (int o = 0; o < NPORT; o++) begin
                if (out_valid[o] && out_ready[o]) begin
                    flit_t f;
                    int src;
                    int sq;
                    f = flit_t'(out_flit[o]);
                    src = int'(f.pay[15:13]);
                    sq = int'(f.pay[12:0]);
                    chk(exp_port(f.row, f.col) == o, "R1/R2 output port", o, exp_port(f.row, f.col));
                    chk(f.cls == CLS, "R10 class field", int'(f.cls), int'(CLS));
                    if (src < NPORT) begin
                        chk(sq > last_seq[src][o], "R9 flow order", sq, last_seq[src][o] + 1);
                        last_seq[src][o] = sq;
                    end
                    if (arr_n[o] < 16) arr_src[o][arr_n[o]] = src;
                    arr_n[o]++;
                    rcvd++;
                end
            end
        end
    end

    // called at a negedge; returns at the negedge after acceptance
    task automatic send(input int src, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
        in_flit[src] = mk(src, r, c);
        in_valid[src] = 1'b1;
        do @(negedge clk); while (!hs_q[src]);
        in_valid[src] = 1'b0;
    endtask

    task automatic drive_rand(input int src, input int n);
        for (int k = 0; k < n; k++) begin
            logic [ROW_W-1:0] r;
            logic [COL_W-1:0] c;
            repeat ($urandom_range(2, 0)) @(negedge clk);
            r = ROW_W'($urandom_range(7, 0));
            c = COL_W'($urandom_range(7, 0));
            case (src)
                0: r = ROW_W'($urandom_range(7, int'(ME_R)));
                1: r = ROW_W'($urandom_range(int'(ME_R), 0));
                2: begin r = ME_R; c = COL_W'($urandom_range(int'(ME_C), 0)); end
                3: begin r = ME_R; c = COL_W'($urandom_range(7, int'(ME_C))); end
                default: ;
            endcase
            send(src, r, c);
        end
    endtask

    task automatic drain(input string tag);
        int k;
        k = 0;
        while (rcvd != sent && k < 3000) begin
            @(negedge clk);
            k++;
        end
        chk(rcvd == sent, tag, rcvd, sent);
    endtask

    task automatic lat_test(input int src, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                            input int o, input int exp_lat, input string tag);
        int t0;
        int k;
        @(negedge clk);
        in_flit[src] = mk(src, r, c);
        in_valid[src] = 1'b1;
        t0 = cyc;
        @(negedge clk);
        in_valid[src] = 1'b0;
        k = 0;
        while (!out_valid[o] && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(cyc - t0 == exp_lat, tag, cyc - t0, exp_lat);
        drain({tag, " delivered"});
    endtask

    task automatic clr_log();
        for (int o = 0; o < NPORT; o++) arr_n[o] = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPORT; i++) begin
            seq_ctr[i] = 0;
            arr_n[i] = 0;
            for (int o = 0; o < NPORT; o++) last_seq[i][o] = -1;
        end
        repeat (4) @(negedge clk);
        chk(out_valid == '0, "R11 out_valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R11 out_valid after reset", int'(out_valid), 0);

        // latency: vertical, horizontal, eject
        lat_test(4, 3'd1, 3'd6, 0, 1, "R5 Y hop north latency");
        lat_test(0, 3'd6, 3'd0, 1, 1, "R5 Y hop south latency");
        lat_test(4, ME_R, 3'd6, 2, 2, "R6 X hop east latency");
        lat_test(2, ME_R, 3'd1, 3, 2, "R6 X hop west latency");
        lat_test(1, ME_R, ME_C, 4, 1, "R7 eject latency");

        // R2: row differs and column differs -> vertical output first
        clr_log();
        @(negedge clk);
        send(4, 3'd5, 3'd7);
        drain("R2 delivered");
        chk(arr_n[1] == 1 && arr_n[2] == 0, "R2 Y before X (south count)", arr_n[1], 1);

        // R3: through vs inject on north
        clr_log();
        @(negedge clk);
        fork
            send(1, 3'd0, 3'd2);
            send(4, 3'd1, 3'd5);
        join
        drain("R3 delivered");
        chk(arr_src[0][0] == 1, "R3 through first on north", arr_src[0][0], 1);
        chk(arr_src[0][1] == 4, "R3 inject second on north", arr_src[0][1], 4);

        // R4: through, turn N, turn S, inject to east
        clr_log();
        @(negedge clk);
        fork
            send(3, ME_R, 3'd7);
            send(0, ME_R, 3'd6);
            send(1, ME_R, 3'd5);
            send(4, ME_R, 3'd7);
        join
        drain("R4 east delivered");
        chk(arr_src[2][0] == 3, "R4 east slot0 through", arr_src[2][0], 3);
        chk(arr_src[2][1] == 0, "R4 east slot1 turn N", arr_src[2][1], 0);
        chk(arr_src[2][2] == 1, "R4 east slot2 turn S", arr_src[2][2], 1);
        chk(arr_src[2][3] == 4, "R4 east slot3 inject", arr_src[2][3], 4);

        // R4: eject order
        clr_log();
        @(negedge clk);
        fork
            send(0, ME_R, ME_C);
            send(1, ME_R, ME_C);
            send(2, ME_R, ME_C);
            send(3, ME_R, ME_C);
            send(4, ME_R, ME_C);
        join
        drain("R4 eject delivered");
        for (int k = 0; k < NPORT; k++)
            chk(arr_src[4][k] == k, "R4 eject order", arr_src[4][k], k);

        // R8: backpressure hold
        begin
            logic [FLIT_W-1:0] snap;
            hold_mask = 5'b00100;
            @(negedge clk);
            send(4, ME_R, 3'd6);
            repeat (3) @(negedge clk);
            snap = out_flit[2];
            chk(out_valid[2] == 1'b1, "R8 held valid", int'(out_valid[2]), 1);
            repeat (4) @(negedge clk);
            chk(out_valid[2] == 1'b1 && out_flit[2] == snap, "R8 held stable",
                int'(out_flit[2][15:0]), int'(snap[15:0]));
            hold_mask = '0;
            drain("R8 released delivered");
        end

        // random phase
        rnd_mode = 1'b1;
        @(negedge clk);
        fork
            drive_rand(0, 300);
            drive_rand(1, 300);
            drive_rand(2, 300);
            drive_rand(3, 300);
            drive_rand(4, 300);
        join
        rnd_mode = 1'b0;
        drain("R8 R9 random no loss");

        summary();
        $finish;
    end
endmodule